// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Flags

This block sits next to a two-port 1K x 8 memory and lets the two ports signal each other. Each port owns one active-low interrupt flag. The opposite port raises that flag by writing a reserved mailbox word. The owning port lowers its flag again by reading the same word. The right port's mailbox is the top word, 0x3FF. The left port's mailbox is the word just below it, 0x3FE. The mailbox words themselves are ordinary memory in the array beside this block. Their 8-bit content means whatever software wants, and this block never looks at data.

Each flag is a two-state machine. `FLAG_IDLE` drives the pin high and `FLAG_RAISED` drives it low. The `RAISE` transition (`FLAG_IDLE` to `FLAG_RAISED`) happens when the peer port writes the mailbox. The `ACK` transition (`FLAG_RAISED` to `FLAG_IDLE`) happens when the owning port reads the mailbox. If neither event occurs, the state holds (`HOLD`). A port whose busy input is low can neither raise nor acknowledge. All inputs are sampled on the rising clock edge, and a flag shows its new value right after the edge in which the access was sampled.

Top module: `dp_mailbox_irq`

## Requirements
- R1: After reset both flags `irq_l_n` and `irq_r_n` are high (deasserted).
- R2: A left-port access with `l_ce_n`=0, `l_rw_n`=0 and `l_addr`=0x3FF, while `l_busy_n`=1, drives `irq_r_n` low after that clock edge.
- R3: A right-port access with `r_ce_n`=0, `r_rw_n`=0 and `r_addr`=0x3FE, while `r_busy_n`=1, drives `irq_l_n` low after that clock edge.
- R4: A right-port access with `r_ce_n`=0, `r_oe_n`=0 and `r_addr`=0x3FF, while `r_busy_n`=1, returns `irq_r_n` high whatever the value of `r_rw_n`.
- R5: A left-port access with `l_ce_n`=0, `l_oe_n`=0 and `l_addr`=0x3FE, while `l_busy_n`=1, returns `irq_l_n` high whatever the value of `l_rw_n`.
- R6: While a port's busy input is low (busy is active low), that port's raise and acknowledge accesses leave both flags unchanged.
- R7: If a raise and an acknowledge of the same flag are sampled in the same cycle, the flag ends low.
- R8: Accesses to other addresses have no effect on either flag. Accesses with chip enable high have no effect. A write with `oe_n` high to a port's own mailbox has no effect. A read with `rw_n` high to the peer's mailbox has no effect.
- R9: With no raise and no acknowledge, each flag keeps its value from one cycle to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_ce_n | input | 1 | Left chip enable, active low |
| l_rw_n | input | 1 | Left read/write; 0 means write |
| l_oe_n | input | 1 | Left output enable, active low |
| l_addr | input | 10 | Left word address |
| l_busy_n | input | 1 | Left busy status, active low |
| r_ce_n | input | 1 | Right chip enable, active low |
| r_rw_n | input | 1 | Right read/write; 0 means write |
| r_oe_n | input | 1 | Right output enable, active low |
| r_addr | input | 10 | Right word address |
| r_busy_n | input | 1 | Right busy status, active low |
| irq_l_n | output | 1 | Interrupt toward the left port, active low |
| irq_r_n | output | 1 | Interrupt toward the right port, active low |

## Verification
Several properties are checked on every cycle:
- a raise request lowers the flag on the following cycle;
- an acknowledge with no raise returns the flag high;
- a flag with no request stays stable;
- both ports busy freezes both flags;
- a qualifying left write to 0x3FF lowers `irq_r_n`.

Only the bench scenarios show the remaining cases:
- the "don't care" treatment of read/write during an acknowledge;
- the addresses and strobes that are ignored;
- single-port busy blocking;
- the set-over-clear priority seen at the pins.

The bench drives long random traffic biased toward the two mailbox words and compares both pins each cycle against its own model.

// File: rtl/dp_mailbox_pkg.sv
package dp_mailbox_pkg;
    typedef enum logic {
        FLAG_IDLE   = 1'b0,
        FLAG_RAISED = 1'b1
    } flag_state_e;

    localparam int SIDE_L = 0;
    localparam int SIDE_R = 1;
    localparam int NUM_SIDES = 2;
endpackage

// File: rtl/dp_mailbox_decode.sv
module dp_mailbox_decode #(
    parameter int          ADDR_W   = 10,
    parameter logic [ADDR_W-1:0] OWN_BOX  = '1,
    parameter logic [ADDR_W-1:0] PEER_BOX = '1
) (
    input  logic              ce_n,
    input  logic              rw_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              busy_n,
    output logic              raise_peer,
    output logic              ack_own
);
    logic enabled;

    always_comb begin
        enabled    = !ce_n && busy_n;
        raise_peer = enabled && !rw_n && (addr == PEER_BOX);
        ack_own    = enabled && !oe_n && (addr == OWN_BOX);
    end
endmodule

// File: rtl/dp_mailbox_flag.sv
module dp_mailbox_flag
    import dp_mailbox_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic raise_i,
    input  logic ack_i,
    output logic flag_n_o
);
    flag_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_IDLE:   if (raise_i) state_d = FLAG_RAISED;
            FLAG_RAISED: if (ack_i && !raise_i) state_d = FLAG_IDLE;
            default:     state_d = FLAG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLAG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        flag_n_o = (state_q != FLAG_RAISED);
    end

    AST_RAISE_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
        raise_i |=> !flag_n_o); // R7
    AST_ACK_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !raise_i) |=> flag_n_o); // R4
    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!raise_i && !ack_i) |=> $stable(flag_n_o)); // R9
endmodule

// File: rtl/dp_mailbox_irq.sv
module dp_mailbox_irq
    import dp_mailbox_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_ce_n,
    input  logic              l_rw_n,
    input  logic              l_oe_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              l_busy_n,
    input  logic              r_ce_n,
    input  logic              r_rw_n,
    input  logic              r_oe_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              r_busy_n,
    output logic              irq_l_n,
    output logic              irq_r_n
);
    localparam logic [ADDR_W-1:0] BOX_R = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] BOX_L = BOX_R - 1'b1;

    logic [NUM_SIDES-1:0]             ce_n, rw_n, oe_n, busy_n;
    logic [NUM_SIDES-1:0][ADDR_W-1:0] addr;
    logic [NUM_SIDES-1:0]             raise_peer, ack_own, flag_n;

    always_comb begin
        ce_n   = {r_ce_n,   l_ce_n};
        rw_n   = {r_rw_n,   l_rw_n};
        oe_n   = {r_oe_n,   l_oe_n};
        busy_n = {r_busy_n, l_busy_n};
        addr[SIDE_L] = l_addr;
        addr[SIDE_R] = r_addr;
    end

    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
        localparam logic [ADDR_W-1:0] OWN  = (s == SIDE_L) ? BOX_L : BOX_R;
        localparam logic [ADDR_W-1:0] PEER = (s == SIDE_L) ? BOX_R : BOX_L;

        dp_mailbox_decode #(
            .ADDR_W  (ADDR_W),
            .OWN_BOX (OWN),
            .PEER_BOX(PEER)
        ) u_dec (
            .ce_n      (ce_n[s]),
            .rw_n      (rw_n[s]),
            .oe_n      (oe_n[s]),
            .addr      (addr[s]),
            .busy_n    (busy_n[s]),
            .raise_peer(raise_peer[s]),
            .ack_own   (ack_own[s])
        );

        dp_mailbox_flag u_flag (
            .clk     (clk),
            .rst_n   (rst_n),
            .raise_i (raise_peer[NUM_SIDES-1-s]),
            .ack_i   (ack_own[s]),
            .flag_n_o(flag_n[s])
        );
    end

    always_comb begin
        irq_l_n = flag_n[SIDE_L];
        irq_r_n = flag_n[SIDE_R];
    end

    AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_busy_n && !r_busy_n) |=> $stable({irq_l_n, irq_r_n})); // R6
    AST_LEFT_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_ce_n && !l_rw_n && (l_addr == BOX_R) && l_busy_n) |=> !irq_r_n); // R2
    AST_RIGHT_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_ce_n && !r_rw_n && (r_addr == BOX_L) && r_busy_n) |=> !irq_l_n); // R3
endmodule

// File: tb/sim_dp_mailbox_irq.sv
`timescale 1ns/1ps
module sim_dp_mailbox_irq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic l_ce_n = 1, l_rw_n = 1, l_oe_n = 1, l_busy_n = 1;
    logic r_ce_n = 1, r_rw_n = 1, r_oe_n = 1, r_busy_n = 1;
    logic [9:0] l_addr = '0, r_addr = '0;
    logic irq_l_n, irq_r_n;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    logic exp_l = 1'b1, exp_r = 1'b1;

    always #2.5 clk = ~clk;

    dp_mailbox_irq u0 (
        .clk(clk), .rst_n(rst_n),
        .l_ce_n(l_ce_n), .l_rw_n(l_rw_n), .l_oe_n(l_oe_n), .l_addr(l_addr), .l_busy_n(l_busy_n),
        .r_ce_n(r_ce_n), .r_rw_n(r_rw_n), .r_oe_n(r_oe_n), .r_addr(r_addr), .r_busy_n(r_busy_n),
        .irq_l_n(irq_l_n), .irq_r_n(irq_r_n)
    );

    function automatic logic next_flag(logic cur, logic raise, logic ack);
        if (raise) return 1'b0;
        if (ack)   return 1'b1;
        return cur;
    endfunction

    task automatic check(string tag);
        checks++;
        if (irq_l_n !== exp_l || irq_r_n !== exp_r) begin
            fails++;
            $display("FAIL %s: irq_l_n=%b irq_r_n=%b expected %b %b",
                     tag, irq_l_n, irq_r_n, exp_l, exp_r);
        end
    endtask

    task automatic step(string tag,
                        logic lce, logic lrw, logic loe, logic [9:0] la, logic lb,
                        logic rce, logic rrw, logic roe, logic [9:0] ra, logic rb);
        logic set_r, clr_r, set_l, clr_l;
        l_ce_n = lce; l_rw_n = lrw; l_oe_n = loe; l_addr = la; l_busy_n = lb;
        r_ce_n = rce; r_rw_n = rrw; r_oe_n = roe; r_addr = ra; r_busy_n = rb;
        set_r = !lce && !lrw && la == 10'h3FF && lb;
        clr_r = !rce && !roe && ra == 10'h3FF && rb;
        set_l = !rce && !rrw && ra == 10'h3FE && rb;
        clr_l = !lce && !loe && la == 10'h3FE && lb;
        @(posedge clk);
        #1;
        exp_r = next_flag(exp_r, set_r, clr_r);
        exp_l = next_flag(exp_l, set_l, clr_l);
        check(tag);
    endtask

    function automatic logic [9:0] pick_addr(int unsigned v);
        case (v % 4)
            0: return 10'h3FE;
            1: return 10'h3FF;
            2: return 10'h3FD;
            default: return 10'($urandom);
        endcase
    endfunction

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset");
        rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1 after release");

        step("R2 left write 3FF", 0,0,1,10'h3FF,1, 1,1,1,10'h000,1);
        step("R9 hold",           1,1,1,10'h000,1, 1,1,1,10'h000,1);
        step("R8 right write own box oe high", 1,1,1,10'h000,1, 0,0,1,10'h3FF,1);
        step("R4 right read 3FF", 1,1,1,10'h000,1, 0,1,0,10'h3FF,1);
        step("R3 right write 3FE", 1,1,1,10'h000,1, 0,0,1,10'h3FE,1);
        step("R6 left ack while busy", 0,1,0,10'h3FE,0, 1,1,1,10'h000,1);
        step("R5 left ack with rw low", 0,0,0,10'h3FE,1, 1,1,1,10'h000,1);
        step("R8 left write 3FE", 0,0,1,10'h3FE,1, 1,1,1,10'h000,1);
        step("R6 left raise while busy", 0,0,1,10'h3FF,0, 1,1,1,10'h000,1);
        step("R8 left read 3FF", 0,1,0,10'h3FF,1, 1,1,1,10'h000,1);
        step("R7 raise and ack together", 0,0,1,10'h3FF,1, 0,1,0,10'h3FF,1);
        step("R9 hold raised",    1,1,1,10'h000,1, 1,1,1,10'h000,1);
        step("R8 other address",  1,1,1,10'h000,1, 0,1,0,10'h3FD,1);
        step("R6 right ack while busy", 1,1,1,10'h000,1, 0,1,0,10'h3FF,0);
        step("R4 right ack rw low", 1,1,1,10'h000,1, 0,0,0,10'h3FF,1);
        step("R8 ce high",        1,0,0,10'h3FF,1, 1,0,0,10'h3FE,1);

        for (int i = 0; i < 3000; i++) begin
            step("random",
                 1'($urandom % 3 == 0), 1'($urandom), 1'($urandom), pick_addr($urandom),
                 1'($urandom % 4 != 0),
                 1'($urandom % 3 == 0), 1'($urandom), 1'($urandom), pick_addr($urandom),
                 1'($urandom % 4 != 0));
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule